// File: doc/BRIEF.md
# Quadrature Subcarrier Phase Generator

This block runs on a clock at four times the colour subcarrier frequency. A two-bit divider splits each subcarrier period into four quarter-period phases. From those phases it makes the sign controls for the two switching modulators that carry the U and V colour-difference signals. U runs on the 0° reference. V runs a quarter period later at 90°. In PAL operation the V carrier is inverted to 270° on every other line.

The block also tells the burst injector two things: which colour-difference channels receive burst on the current line, and with what polarity. NTSC puts an inverted burst on U alone, which gives a 180° burst. PAL puts burst on both channels. Its V polarity follows the line parity, so the burst vector swings between +135° and −135°.

The sync separator supplies two strobes. A line strobe marks each line start and a field strobe marks each field start. The standard select input is sampled only during reset and on these strobes, so a change of standard never happens partway through a line.

Top module: `qsc_phase_gen`

## Requirements
- R1: The phase divider holds phase 0 during reset. It advances by one phase (modulo 4) on every clock edge once reset is released.
- R2: `u_sign` is 1 in phases 0 and 1 and 0 in phases 2 and 3. It is therefore high on the first clock after reset, and it repeats with a period of four clocks.
- R3: `v_sign` equals `u_sign` delayed by one clock (90°) in NTSC and on PAL lines with parity 0. On PAL lines with parity 1 it is the inverse of that delayed value (270°).
- R4: `std_ntsc` = 1 selects NTSC and 0 selects PAL. It is sampled while `rst_n` is low and on a clock edge where `line_stb` or `field_stb` is high. A change at any other time has no effect on any output.
- R5: In PAL, a line strobe toggles `pal_odd`. When NTSC is selected at a strobe or during reset, `pal_odd` is forced to 0.
- R6: A field strobe sets `pal_odd` to 0 and takes priority over a line strobe in the same cycle. Reset also sets `pal_odd` to 0.
- R7: `burst_mask` bit 0 enables burst on U and bit 1 enables burst on V. It reads 2'b01 in NTSC and 2'b11 in PAL.
- R8: `burst_neg` bit 0 (U burst inverted) is always 1. Bit 1 (V burst inverted) equals `pal_odd` in PAL and is 0 in NTSC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the subcarrier frequency |
| rst_n | input | 1 | Synchronous active-low reset |
| std_ntsc | input | 1 | Standard select: 1 = NTSC, 0 = PAL |
| line_stb | input | 1 | One-cycle strobe at each line start |
| field_stb | input | 1 | One-cycle strobe at each field start |
| u_sign | output | 1 | U modulator sign (0° carrier) |
| v_sign | output | 1 | V modulator sign (90° or 270° carrier) |
| pal_odd | output | 1 | Current PAL line parity (1 = V inverted) |
| burst_mask | output | 2 | Burst enable per channel: bit 0 = U, bit 1 = V |
| burst_neg | output | 2 | Burst polarity per channel, 1 = inverted: bit 0 = U, bit 1 = V |

## Verification
Every output is combinational from registers that update on the clock edge that samples the inputs. Each result is therefore due one edge after its stimulus. The bench drives inputs at the falling edge and updates its own model just after the next rising edge, using the values it drove. It compares all outputs at the following falling edge. A change of standard without a strobe is checked on the same cycle, and again on later cycles through `burst_mask`, to show it had no effect before the next strobe.

// File: rtl/qsc_pkg.sv
// Shared constants and types for the quadrature subcarrier phase generator.
// Assumes a clock at four times the subcarrier frequency.
package qsc_pkg;
    localparam int PHASE_W   = 2;                // bits of the phase divider
    localparam int N_PHASES  = 1 << PHASE_W;     // phases per subcarrier period
    localparam int N_CHAN    = 2;                // colour-difference channels (U, V)
    localparam int CH_U      = 0;
    localparam int CH_V      = 1;

    typedef enum logic {
        STD_PAL  = 1'b0,
        STD_NTSC = 1'b1
    } std_e;

    typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/qsc_phase_div.sv
// Divide-by-N_PHASES phase counter. It advances once per clock and holds
// phase 0 during reset.
// Assumes one clock per quarter subcarrier period.
module qsc_phase_div
    import qsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);
    phase_t cnt_q;

    // Phase advance, modulo N_PHASES.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign phase = cnt_q;

    // Cycles since reset, saturating, so that $past is only used on settled values.
    logic age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= 1'b0;
        else        age_q <= 1'b1;
    end

    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        age_q |-> phase == phase_t'($past(phase) + 1'b1))
        else $error("phase divider skipped a step");

    p_phase_zero_r1: assert property (@(posedge clk)
        !rst_n |=> phase == '0)
        else $error("phase not cleared by reset");
endmodule

// File: rtl/qsc_line_alt.sv
// Line-rate state: it latches the standard select and keeps the PAL line
// parity. The select is sampled during reset and on line or field strobes.
// Assumes strobes are single-cycle pulses from the sync separator.
module qsc_line_alt
    import qsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic std_ntsc,
    input  logic line_stb,
    input  logic field_stb,
    output std_e mode,
    output logic parity
);
    std_e mode_q;
    logic par_q;
    logic stb;

    assign stb = line_stb | field_stb;

    // Standard latch: loaded in reset and at each strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n || stb) mode_q <= std_e'(std_ntsc);
    end

    // Parity: cleared by reset, by a field start, or when NTSC is selected; toggled per PAL line.
    always_ff @(posedge clk) begin
        if (!rst_n || field_stb)  par_q <= 1'b0;
        else if (line_stb)        par_q <= std_ntsc ? 1'b0 : ~par_q;
    end

    assign mode   = mode_q;
    assign parity = par_q;

    p_parity_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb && !field_stb && !std_ntsc |=> parity != $past(parity))
        else $error("PAL parity did not toggle on line strobe");

    p_field_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field_stb |=> !parity)
        else $error("field strobe did not clear parity");

    p_ntsc_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == STD_NTSC |-> !parity)
        else $error("parity set while NTSC active");

    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb && !field_stb |=> $stable(mode))
        else $error("standard changed without a strobe");
endmodule

// File: rtl/qsc_sign_map.sv
// Maps the divider phase and line state to the modulator sign bits and
// burst controls. Purely combinational.
// Assumes a 2-bit phase where phase 0 is the 0° reference.
module qsc_sign_map
    import qsc_pkg::*;
(
    input  phase_t           phase,
    input  std_e             mode,
    input  logic             parity,
    output logic             u_sign,
    output logic             v_sign,
    output logic [N_CHAN-1:0] burst_mask,
    output logic [N_CHAN-1:0] burst_neg
);
    logic v_flip;

    // V inverts only on PAL lines with parity set.
    assign v_flip = (mode == STD_PAL) & parity;

    // Carrier signs: U high in the first half period, V one phase later.
    always_comb begin
        u_sign = ~phase[PHASE_W-1];
        v_sign = (phase[PHASE_W-1] ^ phase[PHASE_W-2]) ^ v_flip;
    end

    // Burst routing and polarity per channel.
    always_comb begin
        burst_mask        = '0;
        burst_neg         = '0;
        burst_mask[CH_U]  = 1'b1;
        burst_neg[CH_U]   = 1'b1;
        burst_mask[CH_V]  = (mode == STD_PAL);
        burst_neg[CH_V]   = v_flip;
    end
endmodule

// File: rtl/qsc_phase_gen.sv
// Top of the quadrature subcarrier phase generator. It joins the phase
// divider, the line-rate state and the sign/burst mapping.
// Assumes clk runs at four times the subcarrier frequency and that the
// strobes come from the sync separator in the same clock domain.
module qsc_phase_gen
    import qsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       std_ntsc,
    input  logic       line_stb,
    input  logic       field_stb,
    output logic       u_sign,
    output logic       v_sign,
    output logic       pal_odd,
    output logic [1:0] burst_mask,
    output logic [1:0] burst_neg
);
    phase_t phase;
    std_e   mode;
    logic   parity;

    qsc_phase_div u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    qsc_line_alt u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .std_ntsc  (std_ntsc),
        .line_stb  (line_stb),
        .field_stb (field_stb),
        .mode      (mode),
        .parity    (parity)
    );

    qsc_sign_map u_map (
        .phase      (phase),
        .mode       (mode),
        .parity     (parity),
        .u_sign     (u_sign),
        .v_sign     (v_sign),
        .burst_mask (burst_mask),
        .burst_neg  (burst_neg)
    );

    assign pal_odd = parity;

    // Cycles since reset, saturating at 2, for checks that look back.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 1'b1;
    end

    p_u_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        age_q == 2'd2 |-> u_sign == !$past(u_sign, 2))
        else $error("U sign lost half-period rhythm");

    p_v_lags_u_r3: assert property (@(posedge clk) disable iff (!rst_n)
        age_q != 2'd0 |-> v_sign == ($past(u_sign) ^ (pal_odd && burst_mask[1])))
        else $error("V sign not a quarter period after U");

    p_burst_v_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_neg[1] |-> burst_mask[1] && pal_odd)
        else $error("V burst inverted outside an odd PAL line");

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb && !field_stb |=> $stable(burst_mask))
        else $error("burst mask changed mid-line");
endmodule

// File: tb/qsc_phase_gen_bench.sv
`timescale 1ns/1ps
module qsc_phase_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       std_ntsc = 1'b1;
    logic       line_stb = 1'b0;
    logic       field_stb = 1'b0;
    logic       u_sign, v_sign, pal_odd;
    logic [1:0] burst_mask, burst_neg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state.
    int m_cnt = 0;
    bit m_ntsc = 1;
    bit m_par = 0;

    always #4 clk = ~clk;

    qsc_phase_gen u_qsc_phase_gen (
        .clk(clk), .rst_n(rst_n), .std_ntsc(std_ntsc),
        .line_stb(line_stb), .field_stb(field_stb),
        .u_sign(u_sign), .v_sign(v_sign), .pal_odd(pal_odd),
        .burst_mask(burst_mask), .burst_neg(burst_neg)
    );

    function automatic bit exp_u(int c);
        return c < 2;
    endfunction
    function automatic bit exp_v(int c, bit ntsc, bit par);
        return ((c == 1) || (c == 2)) ^ (!ntsc && par);
    endfunction
    function automatic logic [1:0] exp_mask(bit ntsc);
        return ntsc ? 2'b01 : 2'b11;
    endfunction
    function automatic logic [1:0] exp_neg(bit ntsc, bit par);
        return {(!ntsc && par), 1'b1};
    endfunction

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Apply inputs at a falling edge, pass one rising edge, update the model, compare at the next falling edge.
    task automatic step(input bit r, input bit s, input bit ls, input bit fs);
        rst_n = r; std_ntsc = s; line_stb = ls; field_stb = fs;
        @(posedge clk);
        #1;
        if (!r) begin
            m_cnt = 0; m_ntsc = s; m_par = 0;
        end else begin
            m_cnt = (m_cnt + 1) % 4;
            if (fs) begin
                m_ntsc = s; m_par = 0;
            end else if (ls) begin
                m_ntsc = s; m_par = s ? 1'b0 : ~m_par;
            end
        end
        @(negedge clk);
        chk("R1/R2 u_sign", {1'b0, u_sign}, {1'b0, exp_u(m_cnt)});
        chk("R3 v_sign", {1'b0, v_sign}, {1'b0, exp_v(m_cnt, m_ntsc, m_par)});
        chk("R5/R6 pal_odd", {1'b0, pal_odd}, {1'b0, m_par});
        chk("R4/R7 burst_mask", burst_mask, exp_mask(m_ntsc));
        chk("R8 burst_neg", burst_neg, exp_neg(m_ntsc, m_par));
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0724));
        @(negedge clk);
        // R1: reset state, phase 0 held.
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        chk("R1 reset u_sign high", {1'b0, u_sign}, 2'b01);
        // R2, R3: NTSC free run.
        for (int i = 0; i < 12; i++) step(1, 1, 0, 0);
        // R4: select PAL without a strobe, so NTSC stays in force.
        for (int i = 0; i < 6; i++) step(1, 0, 0, 0);
        chk("R4 no strobe no change", burst_mask, 2'b01);
        // R4, R5: a strobe applies PAL; the parity toggles to 1 on the first PAL line.
        step(1, 0, 1, 0);
        chk("R5 first PAL line odd", {1'b0, pal_odd}, 2'b01);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
        step(1, 0, 1, 0);
        chk("R5 second PAL line even", {1'b0, pal_odd}, 2'b00);
        step(1, 0, 1, 0);
        // R6: field and line strobes together clear the parity.
        step(1, 0, 1, 1);
        chk("R6 field priority", {1'b0, pal_odd}, 2'b00);
        // R5: an NTSC strobe forces the parity to 0.
        step(1, 0, 1, 0);
        step(1, 1, 1, 0);
        chk("R5 NTSC clears parity", {1'b0, pal_odd}, 2'b00);
        // Random mix of the above.
        for (int i = 0; i < 3000; i++) begin
            bit ls, fs, s, r;
            ls = ($urandom % 8) == 0;
            fs = ($urandom % 64) == 0;
            s  = (($urandom % 16) == 0) ? ~std_ntsc : std_ntsc;
            r  = ($urandom % 500) != 0;
            step(r, s, ls, fs);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule